// File: doc/BRIEF.md
# UART host register interface

This block is the processor-facing register file of a UART. It watches three chip-select inputs, a register-select line and a read/write line. From these it routes a byte on the transmit-side bus into the transmit holding register or the line control register, and it drives either the receive holding register or a status byte onto the receive-side bus. A write takes effect only on a clock edge where the bus timing strobe is high. The serial shifter, the receiver and the baud generator sit outside this block. They talk to it through a few simple signals: a pulse when the shifter takes the holding byte, a shifter-idle level, and a load pulse carrying each received byte.

The line control register holds the word-length code, parity enable, even/odd parity select and a stop-bit select. Its top bit is the transmit-request flag. A control write with that flag set changes nothing but the flag, so a port is set up in two writes: first the line format, then the request. While the request flag is set, the request-to-send output is driven low, and an active-low interrupt tells the host that the transmit holding register is free to take a byte. The request flag is only needed for the interrupt and request-to-send. Bytes move through the holding register without it.

Top module: `uart_host_regs`

## Requirements
- R1: With all chip selects true, the strobe high, read/write low and register-select low, the transmit-side byte is loaded into the transmit holding register (`thr_data`), and `thr_full` becomes 1 at the same clock edge. With register-select high, the same access is a control register write.
- R2: While the chip is selected and read/write is high, `rx_bus_oe` is 1 and `rx_bus` carries the receive holding register (register-select low) or the status byte (register-select high). At all other times `rx_bus_oe` is 0 and `rx_bus` is 0.
- R3: No register changes and no read side effect occurs unless `sel_a`=1, `sel_b_n`=0, `sel_c`=1 and `bus_stb`=1 at the clock edge.
- R4: Synchronous reset clears the control fields and the transmit-request flag (`req_send_n`=1), the receive holding register, receive-available, the pending interrupt (`irq_n`=1) and `thr_full`.
- R5: In a control write with bit 7 = 0, bits [1:0] load the word-length code, bit 2 loads parity enable, bit 3 loads even parity, bit 4 loads two-stop-bit select, and the transmit-request flag is cleared. In a control write with bit 7 = 1, the flag is set and bits [4:0] of the stored control fields stay unchanged.
- R6: `req_send_n` is low exactly while the transmit-request flag is set.
- R7: An interrupt becomes pending (`irq_n` low after the edge) when the request flag goes from 0 to 1 while the holding register is empty. It also becomes pending when `hold_taken` empties a full holding register while the flag is set. A new set event wins over a status read at the same edge.
- R8: A status read strobe or a holding-register write clears the pending interrupt. Clearing the request flag also clears it.
- R9: Status byte layout: bit 0 = receive data available, bit 1 = holding register empty, bit 2 = `shifter_idle` as it is now, bit 7 = interrupt pending. Bits 6:3 read 0.
- R10: `rx_load` captures `rx_data` into the receive holding register and sets receive-available. A receive holding read strobe clears receive-available. A load at the same edge wins.
- R11: `hold_taken` clears `thr_full`. A holding-register write at the same edge leaves it set.
- R12: With the request flag clear, holding-register writes and `hold_taken` still work, and `irq_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high clear |
| sel_a | input | 1 | Chip select, active high |
| sel_b_n | input | 1 | Chip select, active low |
| sel_c | input | 1 | Chip select, active high |
| reg_sel | input | 1 | 0: data registers, 1: control/status |
| rd_nwr | input | 1 | 1: read, 0: write |
| bus_stb | input | 1 | Bus timing strobe, qualifies accesses |
| tx_bus | input | 8 | Byte written by the host |
| rx_bus | output | 8 | Byte read by the host |
| rx_bus_oe | output | 1 | High while a read is selected |
| thr_data | output | 8 | Transmit holding byte to the shifter |
| thr_full | output | 1 | Transmit holding register occupied |
| hold_taken | input | 1 | Shifter took the holding byte (pulse) |
| shifter_idle | input | 1 | Shift register empty |
| rx_load | input | 1 | Received byte valid (pulse) |
| rx_data | input | 8 | Received byte |
| req_send_n | output | 1 | Request-to-send, active low |
| irq_n | output | 1 | Holding-empty interrupt, active low |
| len_code | output | 2 | Word length code, length = 5 + code |
| par_en | output | 1 | Parity enable |
| par_even | output | 1 | Even parity when 1 |
| stop2 | output | 1 | Two stop bits when 1 |

## Verification
The hardest cases involve interrupt events that overlap. Two examples: the request flag rising while the holding register is still full, with the interrupt deferred to the later `hold_taken`, and a `hold_taken` in the same cycle as a status read strobe, where the set must win over the clear. Directed sequences set up each case by first filling the holding register and then timing the second event in the exact cycle. After that, a long random phase runs with chip selects, strobe, consume pulses, receive loads and occasional resets biased to collide often. A behavioural model in the bench is compared against every output on every clock.

// File: rtl/uhi_pkg.sv
package uhi_pkg;

    localparam int BUS_W    = 8;
    localparam int TREQ_POS = 7;
    localparam int CFG_W    = 5;

    localparam int ST_AVAIL = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_IDLE  = 2;
    localparam int ST_INT   = 7;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_THR_WR,
        ACC_CTRL_WR,
        ACC_RHR_RD,
        ACC_STAT_RD
    } acc_e;

    // bit 4 stop2, bit 3 even, bit 2 parity enable, bits 1:0 length code
    typedef struct packed {
        logic       stop2;
        logic       par_even;
        logic       par_en;
        logic [1:0] len_code;
    } line_cfg_t;

    function automatic logic [BUS_W-1:0] make_status(
        input logic pend, input logic idle,
        input logic empty, input logic avail);
        logic [BUS_W-1:0] s;
        s           = '0;
        s[ST_INT]   = pend;
        s[ST_IDLE]  = idle;
        s[ST_EMPTY] = empty;
        s[ST_AVAIL] = avail;
        return s;
    endfunction

endpackage

// File: rtl/uhi_decode.sv
module uhi_decode
    import uhi_pkg::*;
(
    input  logic sel_a,
    input  logic sel_b_n,
    input  logic sel_c,
    input  logic reg_sel,
    input  logic rd_nwr,
    input  logic bus_stb,
    output logic chip_hit,
    output logic rd_drive,
    output acc_e acc
);
    always_comb begin
        chip_hit = sel_a & ~sel_b_n & sel_c;
        rd_drive = chip_hit & rd_nwr;
        acc      = ACC_NONE;
        if (chip_hit && bus_stb) begin
            unique case ({reg_sel, rd_nwr})
                2'b00:   acc = ACC_THR_WR;
                2'b01:   acc = ACC_RHR_RD;
                2'b10:   acc = ACC_CTRL_WR;
                default: acc = ACC_STAT_RD;
            endcase
        end
    end
endmodule

// File: rtl/uhi_ctrl_reg.sv
module uhi_ctrl_reg
    import uhi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      treq_in,
    input  line_cfg_t cfg_in,
    output logic      treq,
    output logic      treq_nxt,
    output line_cfg_t cfg
);
    assign treq_nxt = wr_en ? treq_in : treq;

    always_ff @(posedge clk) begin
        if (rst) begin
            treq <= 1'b0;
            cfg  <= '0;
        end else if (wr_en) begin
            treq <= treq_in;
            if (!treq_in) cfg <= cfg_in;
        end
    end

    assert_cfg_locked_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && treq_in) |=> (cfg == $past(cfg)) && treq);
endmodule

// File: rtl/uhi_tx_hold.sv
module uhi_tx_hold
    import uhi_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         thr_wr,
    input  logic [W-1:0] wdata,
    input  logic         hold_taken,
    input  logic         treq_rise,
    input  logic         treq_nxt,
    input  logic         stat_rd,
    output logic [W-1:0] thr_data,
    output logic         thr_full,
    output logic         pend
);
    logic freed;

    assign freed = (treq_rise && !thr_full) || (hold_taken && thr_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_data <= '0;
            thr_full <= 1'b0;
        end else if (thr_wr) begin
            thr_data <= wdata;
            thr_full <= 1'b1;
        end else if (hold_taken) begin
            thr_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !treq_nxt)          pend <= 1'b0;
        else if (freed && !thr_wr)     pend <= 1'b1;
        else if (thr_wr || stat_rd)    pend <= 1'b0;
    end

    assert_thr_load_R11: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> thr_full && (thr_data == $past(wdata)));

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !pend);
endmodule

// File: rtl/uhi_rx_hold.sv
module uhi_rx_hold
    import uhi_pkg::*;
#(
    parameter int W = BUS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rx_load,
    input  logic [W-1:0] rx_data,
    input  logic         rhr_rd,
    output logic [W-1:0] rhr,
    output logic         avail
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rhr   <= '0;
            avail <= 1'b0;
        end else if (rx_load) begin
            rhr   <= rx_data;
            avail <= 1'b1;
        end else if (rhr_rd) begin
            avail <= 1'b0;
        end
    end

    assert_rx_capture_R10: assert property (@(posedge clk) disable iff (rst)
        rx_load |=> avail && (rhr == $past(rx_data)));
endmodule

// File: rtl/uart_host_regs.sv
module uart_host_regs
    import uhi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_a,
    input  logic             sel_b_n,
    input  logic             sel_c,
    input  logic             reg_sel,
    input  logic             rd_nwr,
    input  logic             bus_stb,
    input  logic [BUS_W-1:0] tx_bus,
    output logic [BUS_W-1:0] rx_bus,
    output logic             rx_bus_oe,
    output logic [BUS_W-1:0] thr_data,
    output logic             thr_full,
    input  logic             hold_taken,
    input  logic             shifter_idle,
    input  logic             rx_load,
    input  logic [BUS_W-1:0] rx_data,
    output logic             req_send_n,
    output logic             irq_n,
    output logic [1:0]       len_code,
    output logic             par_en,
    output logic             par_even,
    output logic             stop2
);
    acc_e       acc;
    logic       chip_hit, rd_drive;
    logic       treq, treq_nxt, treq_rise, pend;
    logic       avail;
    line_cfg_t  cfg;
    logic [BUS_W-1:0] rhr;

    uhi_decode u_dec (
        .sel_a(sel_a), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .reg_sel(reg_sel), .rd_nwr(rd_nwr), .bus_stb(bus_stb),
        .chip_hit(chip_hit), .rd_drive(rd_drive), .acc(acc)
    );

    uhi_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst),
        .wr_en(acc == ACC_CTRL_WR),
        .treq_in(tx_bus[TREQ_POS]),
        .cfg_in(line_cfg_t'(tx_bus[CFG_W-1:0])),
        .treq(treq), .treq_nxt(treq_nxt), .cfg(cfg)
    );

    assign treq_rise = (acc == ACC_CTRL_WR) && tx_bus[TREQ_POS] && !treq;

    uhi_tx_hold #(.W(BUS_W)) u_tx (
        .clk(clk), .rst(rst),
        .thr_wr(acc == ACC_THR_WR), .wdata(tx_bus),
        .hold_taken(hold_taken), .treq_rise(treq_rise),
        .treq_nxt(treq_nxt), .stat_rd(acc == ACC_STAT_RD),
        .thr_data(thr_data), .thr_full(thr_full), .pend(pend)
    );

    uhi_rx_hold #(.W(BUS_W)) u_rx (
        .clk(clk), .rst(rst),
        .rx_load(rx_load), .rx_data(rx_data),
        .rhr_rd(acc == ACC_RHR_RD),
        .rhr(rhr), .avail(avail)
    );

    always_comb begin
        rx_bus = '0;
        if (rd_drive)
            rx_bus = reg_sel ? make_status(pend, shifter_idle, !thr_full, avail) : rhr;
    end

    assign rx_bus_oe  = rd_drive;
    assign req_send_n = !treq;
    assign irq_n      = !pend;
    assign len_code   = cfg.len_code;
    assign par_en     = cfg.par_en;
    assign par_even   = cfg.par_even;
    assign stop2      = cfg.stop2;

    assert_unselected_R3: assert property (@(posedge clk) disable iff (rst)
        !chip_hit |=> $stable(cfg) && $stable(req_send_n) && $stable(thr_data));

    assert_rts_on_R6: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_CTRL_WR && tx_bus[TREQ_POS]) |=> !req_send_n);

    assert_irq_needs_req_R12: assert property (@(posedge clk) disable iff (rst)
        req_send_n |-> irq_n);
endmodule

// File: tb/uart_host_regs_bench.sv
module uart_host_regs_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst, sel_a, sel_b_n, sel_c, reg_sel, rd_nwr, bus_stb;
    logic [7:0] tx_bus, rx_bus, thr_data, rx_data;
    logic       rx_bus_oe, thr_full, hold_taken, shifter_idle, rx_load;
    logic       req_send_n, irq_n, par_en, par_even, stop2;
    logic [1:0] len_code;

    uart_host_regs u_uart_host_regs (.*);

    int  total = 0, bad = 0;
    bit  chk_on = 0, done = 0;

    // reference state
    bit       m_treq, m_full, m_avail, m_pend;
    bit [4:0] m_cfg;
    bit [7:0] m_thr, m_rhr;

    always @(posedge clk) begin
        bit sel, wr, rd, thr_w, ctl_w, st_r, rh_r, nt, rise, freed;
        if (rst) begin
            m_treq = 0; m_full = 0; m_avail = 0; m_pend = 0;
            m_cfg = 0; m_thr = 0; m_rhr = 0;
        end else begin
            sel   = sel_a && !sel_b_n && sel_c;
            wr    = sel && bus_stb && !rd_nwr;
            rd    = sel && bus_stb && rd_nwr;
            thr_w = wr && !reg_sel;
            ctl_w = wr && reg_sel;
            st_r  = rd && reg_sel;
            rh_r  = rd && !reg_sel;
            nt    = ctl_w ? tx_bus[7] : m_treq;
            rise  = ctl_w && tx_bus[7] && !m_treq;
            freed = (rise && !m_full) || (hold_taken && m_full);
            if (!nt) m_pend = 0;
            else if (freed && !thr_w) m_pend = 1;
            else if (thr_w || st_r) m_pend = 0;
            if (ctl_w && !tx_bus[7]) m_cfg = tx_bus[4:0];
            m_treq = nt;
            if (thr_w) begin m_thr = tx_bus; m_full = 1; end
            else if (hold_taken) m_full = 0;
            if (rx_load) begin m_rhr = rx_data; m_avail = 1; end
            else if (rh_r) m_avail = 0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        logic [7:0] e_rx;
        logic       e_oe;
        #5;
        if (chk_on && !done) begin
            e_oe = sel_a && !sel_b_n && sel_c && rd_nwr;
            e_rx = !e_oe ? 8'h00 :
                   reg_sel ? {m_pend, 4'b0000, shifter_idle, !m_full, m_avail} : m_rhr;
            chk("R6 req_send_n", req_send_n, !m_treq);
            chk("R7 R8 irq_n", irq_n, !m_pend);
            chk("R1 R3 thr_data", thr_data, m_thr);
            chk("R11 R12 thr_full", thr_full, m_full);
            chk("R5 control fields", {stop2, par_even, par_en, len_code}, m_cfg);
            chk("R2 R9 R10 rx_bus", rx_bus, e_rx);
            chk("R2 rx_bus_oe", rx_bus_oe, e_oe);
        end
    end

    task automatic finish_run();
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    task automatic idle();
        sel_a = 1; sel_b_n = 0; sel_c = 1; bus_stb = 0; rd_nwr = 1; reg_sel = 0;
        tx_bus = 0; hold_taken = 0; rx_load = 0; rx_data = 0;
    endtask

    task automatic acc_cs(input logic rs, input logic rw, input logic [7:0] d,
                          input logic a, input logic bn, input logic c, input logic stb);
        @(negedge clk);
        idle();
        sel_a = a; sel_b_n = bn; sel_c = c; bus_stb = stb;
        reg_sel = rs; rd_nwr = rw; tx_bus = d;
        @(negedge clk);
        idle();
        #6;
    endtask

    task automatic bus_wr(input logic rs, input logic [7:0] d);
        acc_cs(rs, 1'b0, d, 1'b1, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic bus_rd(input logic rs, output logic [7:0] v);
        @(negedge clk);
        idle();
        reg_sel = rs; rd_nwr = 1; bus_stb = 1;
        #6 v = rx_bus;
        @(negedge clk);
        idle();
        #6;
    endtask

    task automatic pulse(input bit take, input bit load, input logic [7:0] d);
        @(negedge clk);
        idle();
        hold_taken = take; rx_load = load; rx_data = d;
        @(negedge clk);
        idle();
        #6;
    endtask

    initial begin
        logic [7:0] v;
        rst = 1; shifter_idle = 1; idle();
        repeat (2) @(negedge clk);
        chk_on = 1;
        rst = 0;
        #6;
        // R4: state after reset
        chk("R4 irq_n after reset", irq_n, 1);
        chk("R4 req_send_n after reset", req_send_n, 1);
        chk("R4 thr_full after reset", thr_full, 0);
        chk("R4 len_code after reset", len_code, 0);
        bus_rd(1, v); chk("R4 R9 status after reset", v, 8'h06);
        bus_rd(0, v); chk("R4 rhr after reset", v, 8'h00);

        // R5 format then request
        bus_wr(1, 8'h1D);
        chk("R5 len_code", len_code, 1);
        chk("R5 parity bits", {stop2, par_even, par_en}, 3'b111);
        bus_wr(1, 8'h82);
        chk("R5 locked len_code", len_code, 1);
        chk("R6 req_send_n low", req_send_n, 0);
        chk("R7 irq on request rise", irq_n, 0);
        bus_rd(1, v); chk("R9 status with pending", v, 8'h86);
        chk("R8 status read clears irq", irq_n, 1);

        // R1 holding write and consume cycle
        bus_wr(0, 8'h5A);
        chk("R1 thr_data", thr_data, 8'h5A);
        chk("R1 thr_full", thr_full, 1);
        bus_rd(1, v); chk("R9 status holding full", v, 8'h04);
        pulse(1, 0, 0);
        chk("R11 taken empties", thr_full, 0);
        chk("R7 irq on consume", irq_n, 0);
        bus_wr(0, 8'hC3);
        chk("R8 thr write clears irq", irq_n, 1);
        pulse(1, 0, 0);
        bus_wr(1, 8'h0E);
        chk("R5 reformat len_code", len_code, 2);
        chk("R5 reformat bits", {stop2, par_even, par_en}, 3'b011);
        chk("R6 req_send_n high", req_send_n, 1);
        chk("R8 request cleared irq", irq_n, 1);

        // R12 transfer without request flag
        bus_wr(0, 8'h33);
        chk("R12 thr_full without request", thr_full, 1);
        pulse(1, 0, 0);
        chk("R12 consumed", thr_full, 0);
        chk("R12 no irq", irq_n, 1);

        // R3 partial selects or no strobe
        acc_cs(1, 0, 8'h1F, 1, 1, 1, 1); chk("R3 sel_b_n high", len_code, 2);
        acc_cs(1, 0, 8'h1F, 0, 0, 1, 1); chk("R3 sel_a low", len_code, 2);
        acc_cs(1, 0, 8'h1F, 1, 0, 0, 1); chk("R3 sel_c low", len_code, 2);
        acc_cs(0, 0, 8'h99, 1, 0, 1, 0); chk("R3 no strobe", thr_data, 8'h33);
        @(negedge clk); idle(); sel_a = 0; #6;
        chk("R2 oe off unselected", rx_bus_oe, 0);
        chk("R2 bus zero unselected", rx_bus, 0);

        // R10 receive side
        pulse(0, 1, 8'hA5);
        bus_rd(1, v); chk("R10 R9 avail in status", v, 8'h07);
        bus_rd(0, v); chk("R10 rhr value", v, 8'hA5);
        bus_rd(1, v); chk("R10 avail cleared", v, 8'h06);
        @(negedge clk); idle(); rx_load = 1; rx_data = 8'h3C; bus_stb = 1; rd_nwr = 1;
        #6 chk("R10 read during load shows old", rx_bus, 8'hA5);
        @(negedge clk); idle(); #6;
        bus_rd(1, v); chk("R10 load wins over read", v, 8'h07);
        bus_rd(0, v); chk("R10 new byte", v, 8'h3C);

        // R7 request rise while holding full, then collisions
        bus_wr(0, 8'h11);
        bus_wr(1, 8'h80);
        chk("R7 no irq while full", irq_n, 1);
        pulse(1, 0, 0);
        chk("R7 irq after consume", irq_n, 0);
        bus_wr(1, 8'h80);
        chk("R7 repeated request keeps irq", irq_n, 0);
        bus_wr(0, 8'h22);
        @(negedge clk); idle(); reg_sel = 1; rd_nwr = 1; bus_stb = 1; hold_taken = 1;
        @(negedge clk); idle(); #6;
        chk("R7 set wins over status read", irq_n, 0);
        bus_wr(1, 8'h00);
        chk("R8 clear request", irq_n, 1);

        // random collisions
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rst          = ($urandom % 250) == 0;
            sel_a        = ($urandom % 8) != 0;
            sel_b_n      = ($urandom % 8) == 0;
            sel_c        = ($urandom % 8) != 0;
            reg_sel      = $urandom;
            rd_nwr       = $urandom;
            bus_stb      = ($urandom % 3) != 0;
            tx_bus       = $urandom;
            hold_taken   = ($urandom % 4) == 0;
            shifter_idle = $urandom;
            rx_load      = ($urandom % 6) == 0;
            rx_data      = $urandom;
        end
        @(negedge clk); rst = 0; idle();
        repeat (2) @(negedge clk);
        #7;
        finish_run();
    end
endmodule